// File: doc/BRIEF.md
# Loop Port Insertion Controller

This block governs when a target's port on an arbitrated loop is switched into the loop and when it is bypassed. It also decides when the port should send loop initialization primitives. It reacts to several inputs: the end of power-on self test, decoded port-enable and port-bypass primitive sequences addressed to it, a loop-failure level seen at the receiver, and initializing LIPs received from the loop. The encoder and decoder on the wire, arbitration and address acquisition are outside the block.

Three static mode bits shape the behaviour, and each acts on its own:

- **Insertion-wait** makes the port stay out of the loop after self test until an enable primitive arrives.
- **Bypass-prevention** makes the port deaf to enable and bypass primitives.
- **Origination-disable** suppresses the initializing LIP that is otherwise sent on insertion.

The two modes that contradict each other (insertion-wait with bypass-prevention) are rejected: the block raises an error flag and keeps the previous mode. Modes are taken in only while the port is bypassed, so a change never disturbs a port that is on the loop.

Top module: `loop_port_ctrl`

## Requirements
- R1: A synchronous active-high reset puts the port in the bypassed, awaiting-self-test state: `port_on` low, both request outputs low, `cfg_error` low, and the latched mode bits all zero.
- R2: With insertion-wait latched as 0, a `selftest_done` strobe sets `port_on` high on the following clock edge.
- R3: With insertion-wait latched as 1, the port stays bypassed after self test. It enables only on an enable primitive whose `lpe_dest` equals `select_id`; enable or bypass primitives with any other destination change nothing.
- R4: With bypass-prevention latched as 0, a bypass primitive addressed to `select_id` takes an enabled port off the loop. An enable primitive addressed to `select_id` puts a bypassed port back on the loop.
- R5: With bypass-prevention latched as 1, all enable and bypass primitives are ignored: an enabled port stays enabled and a bypassed port stays bypassed.
- R6: While the mode bits are being sampled, the input combination insertion-wait=1 with bypass-prevention=1 sets `cfg_error` on the next edge and leaves the latched mode unchanged. A legal combination sampled later clears `cfg_error`.
- R7: With origination-disable latched as 0, `req_init_lip` pulses high in the same cycle that `port_on` first goes high. With origination-disable latched as 1, no pulse accompanies insertion.
- R8: While the port is enabled, a received initializing LIP strobe produces a one-cycle `req_init_lip` pulse on the next edge, whatever origination-disable is. While the port is bypassed, the strobe produces nothing.
- R9: While enabled, a rising `loop_fail` produces a one-cycle `req_fail_lip` pulse on the next edge. Its falling edge produces a one-cycle `req_init_lip` pulse. Both happen whatever origination-disable is.
- R10: While `loop_fail` is high, `req_init_lip` stays low on the next edge. `req_fail_lip` and `req_init_lip` are never high together, so a failure wins over a simultaneous initializing request.
- R11: Mode inputs are sampled only while the port is not enabled. A change made while the port is enabled, including an illegal one, affects neither behaviour nor `cfg_error` until the port is bypassed.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| selftest_done | input | 1 | One-cycle strobe at the end of self test |
| lpe_valid | input | 1 | Enable primitive sequence decoded this cycle |
| lpe_dest | input | ADDR_W | Destination address of the enable primitive |
| lpb_valid | input | 1 | Bypass primitive sequence decoded this cycle |
| lpb_dest | input | ADDR_W | Destination address of the bypass primitive |
| select_id | input | ADDR_W | Port address strapped on the connector pins |
| loop_fail | input | 1 | Level: failure detected at the receive input |
| init_lip_rx | input | 1 | Strobe: initializing LIP received |
| mode_wait_lpe | input | 1 | Insertion-wait mode bit |
| mode_hold_on | input | 1 | Bypass-prevention mode bit |
| mode_no_orig | input | 1 | Origination-disable mode bit |
| port_on | output | 1 | 1 = port inserted in loop, 0 = bypassed |
| req_init_lip | output | 1 | One-cycle request to send an initializing LIP |
| req_fail_lip | output | 1 | One-cycle request to send a loop-failure LIP |
| cfg_error | output | 1 | Last sampled mode combination was illegal |

## Verification
The bench targets primitives addressed to a neighbour. A design without the address compare would toggle the port on traffic meant for others. It submits the illegal mode pair and then inserts the port: a design that latched the pair anyway would stay bypassed instead of using the kept mode. It raises a failure while an initializing LIP arrives, and in the same cycle as one. A design without the priority would emit both requests at once or send an initializing LIP into a broken loop. It also changes modes while the port is enabled; a design that sampled them continuously would ignore a bypass it should obey, or flag an error it should not.

// File: rtl/lpc_pkg.sv
package lpc_pkg;

  typedef enum logic [1:0] {
    LPC_TEST = 2'd0,
    LPC_BYP  = 2'd1,
    LPC_ON   = 2'd2
  } lpc_state_e;

  typedef struct packed {
    logic wait_lpe;
    logic hold_on;
    logic no_orig;
  } lpc_cfg_t;

endpackage

// File: rtl/lpc_cfg_latch.sv
module lpc_cfg_latch
  import lpc_pkg::*;
(
  input  logic     clk,
  input  logic     rst,
  input  logic     sample_en,
  input  lpc_cfg_t cfg_in,
  output lpc_cfg_t cfg_q,
  output logic     cfg_err
);

  logic illegal;
  assign illegal = cfg_in.wait_lpe & cfg_in.hold_on;

  always_ff @(posedge clk) begin
    if (rst) begin
      cfg_q   <= '0;
      cfg_err <= 1'b0;
    end else if (sample_en) begin
      if (illegal) begin
        cfg_err <= 1'b1;
      end else begin
        cfg_q   <= cfg_in;
        cfg_err <= 1'b0;
      end
    end
  end

  // R6: illegal pair flags error and keeps the latched mode
  a_r6_illegal_kept: assert property (@(posedge clk) disable iff (rst)
    (sample_en && cfg_in.wait_lpe && cfg_in.hold_on)
      |=> (cfg_err && $stable(cfg_q)));

  // R11: no mode or error change while sampling is closed
  a_r11_frozen: assert property (@(posedge clk) disable iff (rst)
    (!sample_en) |=> ($stable(cfg_q) && $stable(cfg_err)));

  // R6: latched mode never holds the illegal pair
  a_r6_never_both: assert property (@(posedge clk) disable iff (rst)
    !(cfg_q.wait_lpe && cfg_q.hold_on));

endmodule

// File: rtl/lpc_fsm.sv
module lpc_fsm
  import lpc_pkg::*;
#(
  parameter int ADDR_W = 7
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              test_done,
  input  logic              lpe_v,
  input  logic [ADDR_W-1:0] lpe_dest,
  input  logic              lpb_v,
  input  logic [ADDR_W-1:0] lpb_dest,
  input  logic [ADDR_W-1:0] my_id,
  input  logic              act_wait,
  input  logic              act_hold,
  output lpc_state_e        state_q,
  output logic              insert_evt
);

  logic       lpe_hit;
  logic       lpb_hit;
  lpc_state_e state_d;

  // primitives count only when addressed here and not locked out
  assign lpe_hit = lpe_v && (lpe_dest == my_id) && !act_hold;
  assign lpb_hit = lpb_v && (lpb_dest == my_id) && !act_hold;

  always_comb begin
    state_d    = state_q;
    insert_evt = 1'b0;
    unique case (state_q)
      LPC_TEST: begin
        if (test_done) begin
          if (act_wait) begin
            state_d = LPC_BYP;
          end else begin
            state_d    = LPC_ON;
            insert_evt = 1'b1;
          end
        end
      end
      LPC_BYP: begin
        if (lpe_hit) begin
          state_d    = LPC_ON;
          insert_evt = 1'b1;
        end
      end
      LPC_ON: begin
        if (lpb_hit) state_d = LPC_BYP;
      end
      default: state_d = LPC_TEST;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) state_q <= LPC_TEST;
    else     state_q <= state_d;
  end

  // R2: self insertion when not waiting
  a_r2_self_insert: assert property (@(posedge clk) disable iff (rst)
    (state_q == LPC_TEST && test_done && !act_wait) |=> (state_q == LPC_ON));

  // R3: waiting port stays out after self test
  a_r3_wait_bypass: assert property (@(posedge clk) disable iff (rst)
    (state_q == LPC_TEST && test_done && act_wait) |=> (state_q == LPC_BYP));

  // R3: foreign enable leaves a bypassed port bypassed
  a_r3_foreign_lpe: assert property (@(posedge clk) disable iff (rst)
    (state_q == LPC_BYP && (!lpe_v || lpe_dest != my_id)) |=> (state_q == LPC_BYP));

  // R5: locked port never leaves the loop
  a_r5_hold_on: assert property (@(posedge clk) disable iff (rst)
    (state_q == LPC_ON && act_hold) |=> (state_q == LPC_ON));

endmodule

// File: rtl/lpc_lip_req.sv
module lpc_lip_req (
  input  logic clk,
  input  logic rst,
  input  logic on_loop,
  input  logic insert_evt,
  input  logic no_orig,
  input  logic loop_fail,
  input  logic init_rx,
  output logic req_init_q,
  output logic req_fail_q
);

  logic fail_q;
  logic fail_rise;
  logic fail_fall;
  logic want_fail;
  logic want_init;

  assign fail_rise = loop_fail & ~fail_q;
  assign fail_fall = ~loop_fail & fail_q;
  assign want_fail = on_loop & fail_rise;
  assign want_init = ~loop_fail &
                     ((insert_evt & ~no_orig) | (on_loop & (fail_fall | init_rx)));

  always_ff @(posedge clk) begin
    if (rst) begin
      fail_q     <= 1'b0;
      req_init_q <= 1'b0;
      req_fail_q <= 1'b0;
    end else begin
      fail_q     <= loop_fail;
      req_fail_q <= want_fail;
      req_init_q <= want_init & ~want_fail;
    end
  end

  // R10: the two requests never coincide
  a_r10_exclusive: assert property (@(posedge clk) disable iff (rst)
    !(req_init_q && req_fail_q));

  // R10: no initializing request into a failed input
  a_r10_quiet_fail: assert property (@(posedge clk) disable iff (rst)
    loop_fail |=> !req_init_q);

  // R9: failure request is a single pulse
  a_r9_fail_pulse: assert property (@(posedge clk) disable iff (rst)
    req_fail_q |=> !req_fail_q);

  // R7: silent insertion when origination is disabled
  a_r7_no_orig: assert property (@(posedge clk) disable iff (rst)
    (insert_evt && no_orig) |=> !req_init_q);

endmodule

// File: rtl/loop_port_ctrl.sv
module loop_port_ctrl
  import lpc_pkg::*;
#(
  parameter int ADDR_W = 7
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              selftest_done,
  input  logic              lpe_valid,
  input  logic [ADDR_W-1:0] lpe_dest,
  input  logic              lpb_valid,
  input  logic [ADDR_W-1:0] lpb_dest,
  input  logic [ADDR_W-1:0] select_id,
  input  logic              loop_fail,
  input  logic              init_lip_rx,
  input  logic              mode_wait_lpe,
  input  logic              mode_hold_on,
  input  logic              mode_no_orig,
  output logic              port_on,
  output logic              req_init_lip,
  output logic              req_fail_lip,
  output logic              cfg_error
);

  lpc_cfg_t   cfg_in;
  lpc_cfg_t   cfg_act;
  lpc_state_e state;
  logic       sample_en;
  logic       insert_evt;
  logic       on_loop;

  assign cfg_in    = '{wait_lpe: mode_wait_lpe, hold_on: mode_hold_on, no_orig: mode_no_orig};
  assign on_loop   = (state == LPC_ON);
  assign sample_en = !on_loop;
  assign port_on   = on_loop;

  lpc_cfg_latch u_cfg (
    .clk       (clk),
    .rst       (rst),
    .sample_en (sample_en),
    .cfg_in    (cfg_in),
    .cfg_q     (cfg_act),
    .cfg_err   (cfg_error)
  );

  lpc_fsm #(.ADDR_W(ADDR_W)) u_fsm (
    .clk        (clk),
    .rst        (rst),
    .test_done  (selftest_done),
    .lpe_v      (lpe_valid),
    .lpe_dest   (lpe_dest),
    .lpb_v      (lpb_valid),
    .lpb_dest   (lpb_dest),
    .my_id      (select_id),
    .act_wait   (cfg_act.wait_lpe),
    .act_hold   (cfg_act.hold_on),
    .state_q    (state),
    .insert_evt (insert_evt)
  );

  lpc_lip_req u_req (
    .clk        (clk),
    .rst        (rst),
    .on_loop    (on_loop),
    .insert_evt (insert_evt),
    .no_orig    (cfg_act.no_orig),
    .loop_fail  (loop_fail),
    .init_rx    (init_lip_rx),
    .req_init_q (req_init_lip),
    .req_fail_q (req_fail_lip)
  );

endmodule

// File: tb/tb_loop_port_ctrl.sv
module tb_loop_port_ctrl;
  localparam int CLK_P  = 10;
  localparam int ADDR_W = 7;
  localparam logic [ADDR_W-1:0] MY_ID = 7'h2A;
  localparam logic [ADDR_W-1:0] OTHER = 7'h15;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic selftest_done = 1'b0;
  logic lpe_valid = 1'b0, lpb_valid = 1'b0;
  logic [ADDR_W-1:0] lpe_dest = '0, lpb_dest = '0;
  logic loop_fail = 1'b0, init_lip_rx = 1'b0;
  logic mode_wait_lpe = 1'b0, mode_hold_on = 1'b0, mode_no_orig = 1'b0;
  logic port_on, req_init_lip, req_fail_lip, cfg_error;

  int n_chk = 0;
  int n_err = 0;

  always #(CLK_P/2) clk = ~clk;

  loop_port_ctrl #(.ADDR_W(ADDR_W)) dut (
    .clk(clk), .rst(rst), .selftest_done(selftest_done),
    .lpe_valid(lpe_valid), .lpe_dest(lpe_dest),
    .lpb_valid(lpb_valid), .lpb_dest(lpb_dest),
    .select_id(MY_ID), .loop_fail(loop_fail), .init_lip_rx(init_lip_rx),
    .mode_wait_lpe(mode_wait_lpe), .mode_hold_on(mode_hold_on),
    .mode_no_orig(mode_no_orig), .port_on(port_on),
    .req_init_lip(req_init_lip), .req_fail_lip(req_fail_lip),
    .cfg_error(cfg_error)
  );

  task automatic chk(input string tag, input logic got, input logic exp);
    n_chk++;
    if (got !== exp) begin
      n_err++;
      $display("FAIL %s: got %0d expected %0d", tag, got, exp);
    end
  endtask

  task automatic tick();
    @(posedge clk);
    #1;
  endtask

  task automatic set_cfg(input logic w, input logic h, input logic n);
    mode_wait_lpe = w;
    mode_hold_on  = h;
    mode_no_orig  = n;
  endtask

  task automatic do_reset();
    rst = 1'b1;
    tick();
    tick();
    rst = 1'b0;
    tick();
  endtask

  task automatic pulse_test();
    selftest_done = 1'b1;
    tick();
    selftest_done = 1'b0;
  endtask

  task automatic send_lpe(input logic [ADDR_W-1:0] d);
    lpe_valid = 1'b1;
    lpe_dest  = d;
    tick();
    lpe_valid = 1'b0;
  endtask

  task automatic send_lpb(input logic [ADDR_W-1:0] d);
    lpb_valid = 1'b1;
    lpb_dest  = d;
    tick();
    lpb_valid = 1'b0;
  endtask

  task automatic t_reset();
    set_cfg(1'b0, 1'b0, 1'b0);
    rst = 1'b1;
    tick();
    tick();
    chk("R1 port_on in reset", port_on, 1'b0);
    chk("R1 req_init in reset", req_init_lip, 1'b0);
    chk("R1 req_fail in reset", req_fail_lip, 1'b0);
    chk("R1 cfg_error in reset", cfg_error, 1'b0);
  endtask

  task automatic t_auto_insert();
    set_cfg(1'b0, 1'b0, 1'b0);
    do_reset();
    chk("R1 bypassed before test", port_on, 1'b0);
    pulse_test();
    chk("R2 enabled after test", port_on, 1'b1);
    chk("R7 init on insertion", req_init_lip, 1'b1);
    tick();
    chk("R7 init pulse one cycle", req_init_lip, 1'b0);
    chk("R9 no fail request", req_fail_lip, 1'b0);
    do_reset();
    chk("R1 reset bypasses enabled port", port_on, 1'b0);
  endtask

  task automatic t_wait_insert();
    set_cfg(1'b1, 1'b0, 1'b0);
    do_reset();
    pulse_test();
    chk("R3 stays bypassed after test", port_on, 1'b0);
    tick();
    tick();
    chk("R3 still bypassed", port_on, 1'b0);
    send_lpe(OTHER);
    chk("R3 foreign enable ignored", port_on, 1'b0);
    chk("R3 no init on foreign enable", req_init_lip, 1'b0);
    send_lpe(MY_ID);
    chk("R3 own enable inserts", port_on, 1'b1);
    chk("R7 init on enable insertion", req_init_lip, 1'b1);
  endtask

  task automatic t_bypass();
    set_cfg(1'b0, 1'b0, 1'b1);
    do_reset();
    pulse_test();
    chk("R2 enabled", port_on, 1'b1);
    chk("R7 no init when disabled", req_init_lip, 1'b0);
    send_lpb(OTHER);
    chk("R3 foreign bypass ignored", port_on, 1'b1);
    send_lpb(MY_ID);
    chk("R4 own bypass", port_on, 1'b0);
    send_lpe(MY_ID);
    chk("R4 own enable", port_on, 1'b1);
    chk("R7 no init on reenable", req_init_lip, 1'b0);
  endtask

  task automatic t_hold();
    set_cfg(1'b0, 1'b1, 1'b0);
    do_reset();
    pulse_test();
    chk("R5 enabled with hold", port_on, 1'b1);
    tick();
    send_lpb(MY_ID);
    chk("R5 bypass ignored", port_on, 1'b1);
    tick();
    chk("R5 still enabled", port_on, 1'b1);
  endtask

  task automatic t_illegal();
    set_cfg(1'b0, 1'b0, 1'b0);
    do_reset();
    chk("R6 legal no error", cfg_error, 1'b0);
    set_cfg(1'b1, 1'b1, 1'b0);
    tick();
    chk("R6 illegal flagged", cfg_error, 1'b1);
    set_cfg(1'b0, 1'b0, 1'b0);
    tick();
    chk("R6 error cleared", cfg_error, 1'b0);
    set_cfg(1'b1, 1'b1, 1'b0);
    tick();
    pulse_test();
    chk("R6 old wait=0 kept", port_on, 1'b1);
    send_lpb(MY_ID);
    chk("R6 old hold=0 kept", port_on, 1'b0);
    tick();
    chk("R6 error while bypassed", cfg_error, 1'b1);
  endtask

  task automatic t_answer();
    set_cfg(1'b0, 1'b0, 1'b1);
    do_reset();
    pulse_test();
    tick();
    init_lip_rx = 1'b1;
    tick();
    init_lip_rx = 1'b0;
    chk("R8 answer received LIP", req_init_lip, 1'b1);
    tick();
    chk("R8 answer one cycle", req_init_lip, 1'b0);
    send_lpb(MY_ID);
    init_lip_rx = 1'b1;
    tick();
    init_lip_rx = 1'b0;
    chk("R8 no answer when bypassed", req_init_lip, 1'b0);
  endtask

  task automatic t_failure();
    set_cfg(1'b0, 1'b0, 1'b1);
    do_reset();
    pulse_test();
    tick();
    loop_fail = 1'b1;
    tick();
    chk("R9 fail request", req_fail_lip, 1'b1);
    chk("R10 no init with fail", req_init_lip, 1'b0);
    tick();
    chk("R9 fail pulse one cycle", req_fail_lip, 1'b0);
    init_lip_rx = 1'b1;
    tick();
    init_lip_rx = 1'b0;
    chk("R10 no answer during failure", req_init_lip, 1'b0);
    tick();
    loop_fail = 1'b0;
    tick();
    chk("R9 init on recovery", req_init_lip, 1'b1);
    chk("R9 no fail on recovery", req_fail_lip, 1'b0);
    tick();
    chk("R9 recovery pulse one cycle", req_init_lip, 1'b0);
  endtask

  task automatic t_priority();
    set_cfg(1'b0, 1'b0, 1'b0);
    do_reset();
    pulse_test();
    tick();
    loop_fail   = 1'b1;
    init_lip_rx = 1'b1;
    tick();
    init_lip_rx = 1'b0;
    chk("R10 fail wins", req_fail_lip, 1'b1);
    chk("R10 init dropped", req_init_lip, 1'b0);
    loop_fail = 1'b0;
    tick();
    chk("R9 init after clear", req_init_lip, 1'b1);
  endtask

  task automatic t_freeze();
    set_cfg(1'b0, 1'b0, 1'b0);
    do_reset();
    pulse_test();
    set_cfg(1'b1, 1'b1, 1'b0);
    tick();
    tick();
    chk("R11 no error while enabled", cfg_error, 1'b0);
    set_cfg(1'b0, 1'b1, 1'b0);
    tick();
    send_lpb(MY_ID);
    chk("R11 hold not taken while enabled", port_on, 1'b0);
    tick();
    send_lpe(MY_ID);
    chk("R5 enable ignored under hold", port_on, 1'b0);
  endtask

  initial begin
    t_reset();
    t_auto_insert();
    t_wait_insert();
    t_bypass();
    t_hold();
    t_illegal();
    t_answer();
    t_failure();
    t_priority();
    t_freeze();
    $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    n_chk++;
    n_err++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
    $finish;
  end

endmodule